// File: doc/BRIEF.md
# Bus Cycle Timeout and Partition Window Guard

This block sits beside a bus master controller and watches each bus cycle it runs. A cycle opens when the master starts it. It becomes accepted when a target claims it, and it closes when the cycle completes. Once a target has accepted a cycle, a watchdog counts the cycles until completion. If a programmable limit is reached first, the block issues a one-cycle abort request and sets a sticky timeout fault. This keeps a slow or broken target from stalling the processor indefinitely.

The block also tracks the execution window of the running software partition. The scheduler loads the window length when the partition begins. The block counts it down and removes permission to issue new cycles once fewer cycles remain than a programmed guard interval. Any cycle that is still open when the window runs out sets a sticky overrun fault, separate from the timeout fault, so one partition's bus traffic cannot spill into the next partition's time.

Top module: `bus_cycle_guard`

## Requirements
- R1: While reset is asserted and right after it, `issue_en`, `abort_req`, `to_fault` and `ovr_fault` are all 0.
- R2: A high `part_start` at a clock edge loads `part_len` as the remaining window count. With no reload, each edge lowers a nonzero count by one. `issue_en` is 1 exactly when the remaining count is nonzero and not less than `guard_len`.
- R3: A `cyc_start` sampled while `issue_en` is 0 is ignored: no cycle is tracked, so it can cause neither a timeout nor an overrun.
- R4: If a cycle accepted at edge E is not completed at any edge E+1..E+L (L = `to_limit`), the timeout occurs at edge E+L. A completion at or before E+L prevents it.
- R5: A timeout raises `abort_req` for exactly one cycle and drops the tracked cycle, so a later completion or window end finds no open cycle.
- R6: `to_fault` is set by a timeout and holds until `fault_clr` is sampled high. A timeout in the same cycle as `fault_clr` leaves it set.
- R7: At the edge where the remaining window count goes from 1 to 0 without a reload, a cycle that is open (started and not completed at that edge) sets the sticky `ovr_fault`. `fault_clr` clears it, and a new set wins over a clear. A timeout alone never sets `ovr_fault`.
- R8: When a timeout and the window end fall on the same edge, both `to_fault` and `ovr_fault` are set.
- R9: A cycle whose completion is sampled at the window-end edge does not cause an overrun.
- R10: A `to_limit` of 0 behaves like 1: the timeout occurs one edge after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start | input | 1 | Master starts a bus cycle (pulse) |
| tgt_accept | input | 1 | Target claims the open cycle (pulse) |
| cyc_done | input | 1 | Open cycle completes (pulse) |
| part_start | input | 1 | Partition window begins; load length (pulse) |
| part_len | input | WIN_W | Window length in clock cycles |
| guard_len | input | WIN_W | Guard interval before window end |
| to_limit | input | CNT_W | Accept-to-complete limit in clock cycles |
| fault_clr | input | 1 | Clear both sticky faults |
| issue_en | output | 1 | New bus cycles may be started |
| abort_req | output | 1 | One-cycle forced abort of the stuck cycle |
| to_fault | output | 1 | Sticky timeout fault |
| ovr_fault | output | 1 | Sticky window overrun fault |

## Verification
`issue_en` is a combinational function of the registered window count, so it changes in the cycle that follows the loading or counting edge. `abort_req`, `to_fault` and `ovr_fault` are registered and appear just after the edge where the timeout or window end is sampled. That edge is the L-th edge after acceptance, or the edge where the count passes from 1 to 0. The bench drives inputs 1 ns after a rising edge and updates a behavioural model at that edge. It compares all four outputs with the model 1 ns after every edge, so each result is checked in the cycle it is due. Directed cases place completion, timeout and window end on coinciding edges.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE = 2'd0,
    CYC_REQ  = 2'd1,
    CYC_ACC  = 2'd2
  } cyc_state_e;
endpackage

// File: rtl/bcg_window.sv
module bcg_window #(
  parameter int WIN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             part_start,
  input  logic [WIN_W-1:0] part_len,
  input  logic [WIN_W-1:0] guard_len,
  output logic             issue_en,
  output logic             win_end
);
  localparam logic [WIN_W-1:0] ONE = {{(WIN_W-1){1'b0}}, 1'b1};

  logic [WIN_W-1:0] win_q, win_d;
  logic             win_en;

  always_comb begin
    win_en = 1'b0;
    win_d  = win_q;
    if (part_start) begin
      win_en = 1'b1;
      win_d  = part_len;
    end else if (win_q != '0) begin
      win_en = 1'b1;
      win_d  = win_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      win_q <= '0;
    else if (win_en) win_q <= win_d;
  end

  assign issue_en = (win_q != '0) && (win_q >= guard_len);
  assign win_end  = (win_q == ONE) && !part_start;

  // R2
  win_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!part_start && win_q != '0) |=> (win_q == $past(win_q) - ONE));

  // R2
  win_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    part_start |=> (win_q == $past(part_len)));
endmodule

// File: rtl/bcg_cycle_timer.sv
module bcg_cycle_timer
  import bcg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_start,
  input  logic             issue_en,
  input  logic             tgt_accept,
  input  logic             cyc_done,
  input  logic [CNT_W-1:0] to_limit,
  output logic             to_hit,
  output logic             open_at_edge
);
  localparam int EXT_W = CNT_W + 1;

  cyc_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic [EXT_W-1:0] elapsed;
  logic             limit_reached;

  assign elapsed       = {1'b0, cnt_q} + EXT_W'(1);
  assign limit_reached = elapsed >= {1'b0, to_limit};

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    to_hit  = 1'b0;
    case (state_q)
      CYC_IDLE: if (cyc_start && issue_en) state_d = CYC_REQ;
      CYC_REQ: begin
        if (cyc_done) state_d = CYC_IDLE;
        else if (tgt_accept) begin
          state_d = CYC_ACC;
          cnt_en  = 1'b1;
          cnt_d   = '0;
        end
      end
      CYC_ACC: begin
        if (cyc_done) state_d = CYC_IDLE;
        else if (limit_reached) begin
          to_hit  = 1'b1;
          state_d = CYC_IDLE;
        end else begin
          cnt_en = 1'b1;
          cnt_d  = cnt_q + 1'b1;
        end
      end
      default: state_d = CYC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= CYC_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign open_at_edge = (state_q != CYC_IDLE) && !cyc_done;

  // R3
  blocked_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CYC_IDLE && !issue_en) |=> (state_q == CYC_IDLE));

  // R5
  drop_after_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    to_hit |=> (state_q == CYC_IDLE));
endmodule

// File: rtl/bus_cycle_guard.sv
module bus_cycle_guard #(
  parameter int WIN_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_start,
  input  logic             tgt_accept,
  input  logic             cyc_done,
  input  logic             part_start,
  input  logic [WIN_W-1:0] part_len,
  input  logic [WIN_W-1:0] guard_len,
  input  logic [CNT_W-1:0] to_limit,
  input  logic             fault_clr,
  output logic             issue_en,
  output logic             abort_req,
  output logic             to_fault,
  output logic             ovr_fault
);
  logic win_end, to_hit, open_at_edge;
  logic abort_q, abort_d;
  logic to_q, to_d, ovr_q, ovr_d;

  bcg_window #(.WIN_W(WIN_W)) u_window (
    .clk       (clk),
    .rst_n     (rst_n),
    .part_start(part_start),
    .part_len  (part_len),
    .guard_len (guard_len),
    .issue_en  (issue_en),
    .win_end   (win_end)
  );

  bcg_cycle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .cyc_start   (cyc_start),
    .issue_en    (issue_en),
    .tgt_accept  (tgt_accept),
    .cyc_done    (cyc_done),
    .to_limit    (to_limit),
    .to_hit      (to_hit),
    .open_at_edge(open_at_edge)
  );

  always_comb begin
    abort_d = to_hit;
    to_d    = to_q;
    ovr_d   = ovr_q;
    if (to_hit)         to_d = 1'b1;
    else if (fault_clr) to_d = 1'b0;
    if (win_end && open_at_edge) ovr_d = 1'b1;
    else if (fault_clr)          ovr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      abort_q <= 1'b0;
      to_q    <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      abort_q <= abort_d;
      to_q    <= to_d;
      ovr_q   <= ovr_d;
    end
  end

  assign abort_req = abort_q;
  assign to_fault  = to_q;
  assign ovr_fault = ovr_q;

  // R5
  abort_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |=> !abort_req);

  // R4
  abort_with_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |-> to_fault);

  // R6
  to_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (to_fault && !fault_clr) |=> to_fault);

  // R7
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_fault && !fault_clr) |=> ovr_fault);
endmodule

// File: tb/tb_bus_cycle_guard.sv
`timescale 1ns/1ps
module tb_bus_cycle_guard;
  localparam int WIN_W = 16;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_start = 1'b0, tgt_accept = 1'b0, cyc_done = 1'b0;
  logic part_start = 1'b0, fault_clr = 1'b0;
  logic [WIN_W-1:0] part_len = '0, guard_len = '0;
  logic [CNT_W-1:0] to_limit = '0;
  logic issue_en, abort_req, to_fault, ovr_fault;

  int tests = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bus_cycle_guard #(.WIN_W(WIN_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .tgt_accept(tgt_accept),
    .cyc_done(cyc_done), .part_start(part_start), .part_len(part_len),
    .guard_len(guard_len), .to_limit(to_limit), .fault_clr(fault_clr),
    .issue_en(issue_en), .abort_req(abort_req), .to_fault(to_fault),
    .ovr_fault(ovr_fault));

  // behavioural reference: 0 none, 1 started, 2 accepted
  int m_st, m_cnt, m_win;
  bit m_abort, m_to, m_ovr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_win = 0; m_abort = 0; m_to = 0; m_ovr = 0;
    end else begin
      bit hit, open, wend, ien;
      int lim;
      hit  = 0;
      lim  = (to_limit == 0) ? 1 : int'(to_limit);
      open = (m_st != 0) && !cyc_done;
      wend = (m_win == 1) && !part_start;
      ien  = (m_win != 0) && (m_win >= int'(guard_len));
      if (m_st == 0) begin
        if (cyc_start && ien) m_st = 1;
      end else if (m_st == 1) begin
        if (cyc_done) m_st = 0;
        else if (tgt_accept) begin m_st = 2; m_cnt = 0; end
      end else begin
        if (cyc_done) m_st = 0;
        else if (m_cnt + 1 >= lim) begin hit = 1; m_st = 0; end
        else m_cnt++;
      end
      m_abort = hit;
      if (hit) m_to = 1; else if (fault_clr) m_to = 0;
      if (wend && open) m_ovr = 1; else if (fault_clr) m_ovr = 0;
      if (part_start) m_win = int'(part_len);
      else if (m_win != 0) m_win--;
    end
  end

  task automatic check(input bit act, input bit exp, input string req);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0b expected %0b", req, $time, act, exp);
    end
  endtask

  // one clock: inputs set before the call are sampled at this edge
  task automatic tick();
    bit m_ien;
    @(posedge clk);
    #1;
    m_ien = (m_win != 0) && (m_win >= int'(guard_len));
    check(issue_en,  m_ien,   "R2 R3 issue_en");
    check(abort_req, m_abort, "R4 R5 abort_req");
    check(to_fault,  m_to,    "R4 R6 R10 to_fault");
    check(ovr_fault, m_ovr,   "R7 R8 R9 ovr_fault");
    cyc_start = 0; tgt_accept = 0; cyc_done = 0; part_start = 0; fault_clr = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic clear_faults();
    fault_clr = 1; tick();
  endtask

  initial begin
    #1;
    check(issue_en | abort_req | to_fault | ovr_fault, 1'b0, "R1 in reset");
    #10 rst_n = 1;
    tick();
    check(issue_en | abort_req | to_fault | ovr_fault, 1'b0, "R1 after reset");

    // normal completed cycle inside a window
    part_len = 40; guard_len = 8; to_limit = 5;
    part_start = 1; tick();
    check(issue_en, 1'b1, "R2 window open");
    cyc_start = 1; tick();
    tgt_accept = 1; tick();
    ticks(4);
    cyc_done = 1; tick();  // done at edge E+5 with L=5: no timeout
    check(to_fault, 1'b0, "R4 done at limit edge");

    // stuck target: timeout at E+5
    cyc_start = 1; tick();
    tgt_accept = 1; tick();
    ticks(4);
    check(abort_req, 1'b0, "R4 not yet");
    tick();
    check(abort_req, 1'b1, "R4 abort due");
    check(to_fault, 1'b1, "R6 set");
    check(ovr_fault, 1'b0, "R7 timeout alone");
    tick();
    check(abort_req, 1'b0, "R5 single pulse");
    cyc_done = 1; tick();  // late completion of dropped cycle
    ticks(3);
    check(to_fault, 1'b1, "R6 held");
    clear_faults();
    check(to_fault, 1'b0, "R6 cleared");

    // run into guard band, blocked start, window end with nothing open
    while (issue_en) tick();
    check(issue_en, 1'b0, "R2 guard band");
    cyc_start = 1; tick();
    tgt_accept = 1; tick();
    ticks(12);
    check(ovr_fault | to_fault, 1'b0, "R3 blocked start ignored");

    // overrun: guard 0, cycle open at window end
    to_limit = 100; guard_len = 0; part_len = 10;
    part_start = 1; tick();
    ticks(4);
    cyc_start = 1; tick();
    tgt_accept = 1; tick();
    ticks(6);
    check(ovr_fault, 1'b1, "R7 overrun");
    check(issue_en, 1'b0, "R2 window closed");
    cyc_done = 1; tick();
    clear_faults();
    check(ovr_fault, 1'b0, "R7 cleared");

    // timeout and window end on the same edge
    part_len = 12; to_limit = 10;
    part_start = 1; tick();
    cyc_start = 1; tick();
    tgt_accept = 1; tick();
    ticks(9);
    check(ovr_fault | to_fault, 1'b0, "R8 before edge");
    tick();
    check(to_fault & ovr_fault & abort_req, 1'b1, "R8 both set");
    clear_faults();

    // completion on the window-end edge
    part_len = 6; to_limit = 50;
    part_start = 1; tick();
    cyc_start = 1; tick();
    tgt_accept = 1; tick();
    ticks(3);
    cyc_done = 1; tick();
    check(ovr_fault, 1'b0, "R9 done at end");

    // limit 0 and set-over-clear
    part_len = 30; to_limit = 0;
    part_start = 1; tick();
    cyc_start = 1; tick();
    tgt_accept = 1; tick();
    fault_clr = 1; tick();
    check(abort_req, 1'b1, "R10 limit zero");
    check(to_fault, 1'b1, "R6 set wins over clear");
    clear_faults();
    ticks(40);

    rst_n = 0; #3;
    check(issue_en | abort_req | to_fault | ovr_fault, 1'b0, "R1 reset again");
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule